// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD. A single enable input, `tick`, pulses once per cycle of a slow crystal timebase; a prescaler divides those pulses down to one-second boundaries. On each boundary the seconds field advances, and carries move up through minutes, 24-hour hours, day-of-week, day-of-month, month and two-digit year. A century flag that shares a byte with the hours toggles on a year wrap when enabled. The date wraps at the length of the current month, and February gets a 29th day in years divisible by four.

A host writes any of the eight byte registers through a one-cycle write strobe. All eight bytes are always visible on one flat output bus, so a serial front end can stream them out in address order. Byte `i` sits on bits `[8*i+7:8*i]`. The byte order is: seconds (0), minutes (1), century/hours (2), day-of-week (3), date (4), month (5), year (6), calibration (7). The calibration byte is only stored.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the bytes read, from address 0 to 7: 00, 00, 00, 01, 01, 01, 00, 00.
- R2: Seconds advance by one in BCD (09 goes to 10) once every PRESCALE `tick` pulses. Cycles without `tick` do not count.
- R3: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours.
- R4: Hours (byte 2, bits 5:0) count 00 to 23 in 24-hour form. The 23 to 00 wrap advances both the day-of-week and the date.
- R5: Day-of-week (byte 3) counts 1 to 7 and goes from 7 back to 1 at midnight, independently of the date.
- R6: The date wraps to 01 after the last day of the month and advances the month. April, June, September and November have 30 days, February has 28 in a non-leap year, and all other months have 31.
- R7: In a year whose value is divisible by four, February has 29 days.
- R8: The month wraps from 12 to 01 and advances the year. The year wraps from 99 to 00.
- R9: Byte 2 bit 6 enables the century flag and bit 7 holds it. On a 99 to 00 year wrap, bit 7 inverts only when bit 6 is set.
- R10: A write (`wr_en` high with `wr_addr` and `wr_data`) loads the addressed byte on the next clock edge. Unused bits are forced to zero: bit 7 of the seconds and minutes bytes, bits 7:3 of the day-of-week byte, bits 7:6 of the date byte and bits 7:5 of the month byte. A write to the seconds byte restarts the prescaler, so the next advance comes a full PRESCALE pulses later.
- R11: When a write and a carry reach the same byte in the same cycle, the written value is kept. A seconds write on a boundary cycle cancels that advance.
- R12: The calibration byte (address 7) holds whatever was written and has no effect on counting.
- R13: Each field appears at the byte position of its address on `regs_flat`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per timebase period |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Byte address of the write |
| wr_data | input | 8 | Byte to be written |
| regs_flat | output | 64 | All eight bytes, byte i at bits 8i+7 down to 8i |

## Verification
The hardest situation to reach from the ports is a host write that lands in exactly the cycle where a second boundary is carrying into the written field. Random writes almost never hit it. To reach it, the bench writes the seconds byte to 59, which also restarts the prescaler. It then holds `tick` high every cycle so the next boundary falls a known number of edges later, and places a minutes write on that exact edge. The month-end, leap-February and century-enabled year wraps are reached the same way: the bench loads a time one second before the event, so the rare rollover happens within a handful of cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_BYTES = 8;
    localparam int NUM_CTR   = 7;
    localparam int ADDR_W    = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_SEC  = 3'd0,
        RA_MIN  = 3'd1,
        RA_HRS  = 3'd2,
        RA_DOW  = 3'd3,
        RA_DATE = 3'd4,
        RA_MON  = 3'd5,
        RA_YEAR = 3'd6,
        RA_CAL  = 3'd7
    } reg_addr_e;

    // Increment a two-digit packed BCD value (no range wrap here).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Divisible by four, evaluated directly on the two BCD digits.
    function automatic logic bcd_is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic logic [7:0] ctr_floor(input int k);
        return (k == 3 || k == 4 || k == 5) ? 8'h01 : 8'h00;
    endfunction

    function automatic logic [7:0] ctr_ceiling(input int k);
        case (k)
            0, 1:    return 8'h59;
            2:       return 8'h23;
            3:       return 8'h07;
            4:       return 8'h31;
            5:       return 8'h12;
            default: return 8'h99;
        endcase
    endfunction

    function automatic logic [7:0] reg_mask(input int k);
        case (k)
            0, 1:    return 8'h7F;
            2:       return 8'h3F;
            3:       return 8'h07;
            4:       return 8'h3F;
            5:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic sec_pulse
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic             at_last;

    assign at_last   = (cnt == LAST);
    // A restart request suppresses the boundary of the same cycle.
    assign sec_pulse = tick && at_last && !clr;

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (tick)    cnt <= at_last ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/rtc_bcd_ctr.sv
module rtc_bcd_ctr
    import rtc_pkg::*;
#(
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic [7:0] lo,
    input  logic [7:0] hi,
    output logic [7:0] q,
    output logic       at_hi
);
    // BCD values order like binary, so >= also catches a date left
    // above a shorter month's limit after a host write.
    assign at_hi = (q >= hi);

    always_ff @(posedge clk) begin
        if (!rst_n)   q <= RST_VAL;
        else if (ld)  q <= ld_val;
        else if (inc) q <= at_hi ? lo : bcd_inc(q);
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    output logic [NUM_BYTES*8-1:0]  regs_flat
);
    logic             sec_pulse;
    logic             sec_wr;
    logic [7:0]       ctr_q     [NUM_CTR];
    logic [7:0]       ctr_hi    [NUM_CTR];
    logic [7:0]       ctr_ldv   [NUM_CTR];
    logic [NUM_CTR-1:0] ctr_ld;
    logic [NUM_CTR-1:0] ctr_inc;
    logic [NUM_CTR-1:0] ctr_at_hi;
    logic             day_roll;
    logic             year_roll;
    logic             cen_en;
    logic             cen_bit;
    logic [7:0]       cal_q;

    assign sec_wr = wr_en && (wr_addr == RA_SEC);

    rtc_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clr       (sec_wr),
        .sec_pulse (sec_pulse)
    );

    // Carry chain: each field advances when everything below it wraps.
    assign ctr_inc[0] = sec_pulse;
    assign ctr_inc[1] = ctr_inc[0] && ctr_at_hi[0];
    assign ctr_inc[2] = ctr_inc[1] && ctr_at_hi[1];
    assign day_roll   = ctr_inc[2] && ctr_at_hi[2];
    assign ctr_inc[3] = day_roll;
    assign ctr_inc[4] = day_roll;
    assign ctr_inc[5] = ctr_inc[4] && ctr_at_hi[4];
    assign ctr_inc[6] = ctr_inc[5] && ctr_at_hi[5];
    assign year_roll  = ctr_inc[6] && ctr_at_hi[6];

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        localparam logic [7:0] FLOOR = ctr_floor(k);

        assign ctr_ld[k]  = wr_en && (wr_addr == ADDR_W'(k));
        assign ctr_ldv[k] = wr_data & reg_mask(k);

        if (k == int'(RA_DATE)) begin : g_dyn
            assign ctr_hi[k] = month_last_day(ctr_q[RA_MON], bcd_is_leap(ctr_q[RA_YEAR]));
        end else begin : g_fix
            assign ctr_hi[k] = ctr_ceiling(k);
        end

        rtc_bcd_ctr #(.RST_VAL(FLOOR)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (ctr_inc[k]),
            .ld     (ctr_ld[k]),
            .ld_val (ctr_ldv[k]),
            .lo     (FLOOR),
            .hi     (ctr_hi[k]),
            .q      (ctr_q[k]),
            .at_hi  (ctr_at_hi[k])
        );
    end

    // Century flags live beside the hours counter; a write there wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_en  <= 1'b0;
            cen_bit <= 1'b0;
        end else if (ctr_ld[RA_HRS]) begin
            cen_en  <= wr_data[6];
            cen_bit <= wr_data[7];
        end else if (year_roll && cen_en) begin
            cen_bit <= !cen_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              cal_q <= 8'h00;
        else if (wr_en && (wr_addr == RA_CAL))   cal_q <= wr_data;
    end

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_out
        if (b == int'(RA_HRS)) begin : g_hrs
            assign regs_flat[8*b +: 8] = {cen_bit, cen_en, ctr_q[b][5:0]};
        end else if (b == int'(RA_CAL)) begin : g_cal
            assign regs_flat[8*b +: 8] = cal_q;
        end else begin : g_cnt
            assign regs_flat[8*b +: 8] = ctr_q[b];
        end
    end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [63:0] regs_flat,
    input logic        sec_pulse
);
    // R10: with no boundary and no write, nothing moves.
    p_quiet_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_pulse && !wr_en) |=> $stable(regs_flat));

    // R12: the calibration byte changes only through its own write.
    p_cal_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 3'd7) |=> $stable(regs_flat[63:56]));

    // R4: hours never leave 00..23.
    p_hours_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        regs_flat[21:16] <= 6'h23);

    // R5: day-of-week stays within 1..7.
    p_dow_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_flat[31:24] >= 8'h01) && (regs_flat[31:24] <= 8'h07));

    // R6: the date is never zero.
    p_date_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        regs_flat[39:32] != 8'h00);

    // R3: a boundary at second 59 moves the minutes unless they are written.
    p_min_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && regs_flat[7:0] == 8'h59 && !(wr_en && wr_addr == 3'd1))
        |=> (regs_flat[15:8] != $past(regs_flat[15:8])));

    // R2: a boundary below 59 leaves the minutes alone.
    p_no_early_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && regs_flat[7:0] != 8'h59 && !wr_en) |=> $stable(regs_flat[15:8]));
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .regs_flat (regs_flat),
    .sec_pulse (sec_pulse)
);

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        tick_rnd = 1'b1;
    logic        gap_en = 1'b0;
    logic        tick;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [63:0] regs_flat;

    int vectors = 0;
    int fails = 0;
    bit cmp_on = 0;
    bit done = 0;

    always #4 clk = !clk;
    assign tick = tick_en && tick_rnd;

    rtc_calendar_core #(.PRESCALE(P)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .regs_flat(regs_flat)
    );

    // ---------------- reference model ----------------
    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_pc;
    bit m_ce, m_cb;
    logic [7:0] m_cal;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction
    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic int days_in(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1;
            m_mon = 1; m_yr = 0; m_pc = 0; m_ce = 0; m_cb = 0; m_cal = 0;
        end else begin
            bit sw, pulse;
            sw = wr_en && wr_addr == 3'd0;
            pulse = tick && (m_pc == P - 1) && !sw;
            if (sw) m_pc = 0;
            else if (tick) m_pc = (m_pc == P - 1) ? 0 : m_pc + 1;
            if (pulse) begin
                m_sec++;
                if (m_sec == 60) begin
                    m_sec = 0; m_min++;
                    if (m_min == 60) begin
                        m_min = 0; m_hr++;
                        if (m_hr == 24) begin
                            m_hr = 0;
                            m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                            m_date++;
                            if (m_date > days_in(m_mon, m_yr)) begin
                                m_date = 1; m_mon++;
                                if (m_mon == 13) begin
                                    m_mon = 1; m_yr++;
                                    if (m_yr == 100) begin
                                        m_yr = 0;
                                        if (m_ce) m_cb = !m_cb;
                                    end
                                end
                            end
                        end
                    end
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_sec  = from_bcd(wr_data & 8'h7F);
                    3'd1: m_min  = from_bcd(wr_data & 8'h7F);
                    3'd2: begin m_hr = from_bcd(wr_data & 8'h3F); m_ce = wr_data[6]; m_cb = wr_data[7]; end
                    3'd3: m_dow  = int'(wr_data[2:0]);
                    3'd4: m_date = from_bcd(wr_data & 8'h3F);
                    3'd5: m_mon  = from_bcd(wr_data & 8'h1F);
                    3'd6: m_yr   = from_bcd(wr_data);
                    default: m_cal = wr_data;
                endcase
            end
        end
    end

    function automatic logic [7:0] byte_at(input int i);
        return regs_flat[8*i +: 8];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison of every byte against the model.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R2 seconds",   byte_at(0), to_bcd(m_sec));
            check("R3 minutes",   byte_at(1), to_bcd(m_min));
            check("R4/R9 hours",  byte_at(2), {m_cb, m_ce, to_bcd(m_hr)[5:0]});
            check("R5 weekday",   byte_at(3), to_bcd(m_dow));
            check("R6 date",      byte_at(4), to_bcd(m_date));
            check("R8 month",     byte_at(5), to_bcd(m_mon));
            check("R8 year",      byte_at(6), to_bcd(m_yr));
            check("R12 calib",    byte_at(7), m_cal);
        end
    end

    always @(negedge clk) tick_rnd = gap_en ? ($urandom % 4 != 0) : 1'b1;

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Loads a full time with ticks held off; the seconds write goes last
    // and restarts the prescaler with ticks running from that edge.
    task automatic set_all(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                           input logic [7:0] y);
        tick_en = 1'b0;
        wr_reg(3'd1, mi); wr_reg(3'd2, h); wr_reg(3'd3, dw);
        wr_reg(3'd4, dt); wr_reg(3'd5, mo); wr_reg(3'd6, y);
        tick_en = 1'b1;
        wr_reg(3'd0, s);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual still running, expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset contents
        check("R1 byte0", byte_at(0), 8'h00); check("R1 byte1", byte_at(1), 8'h00);
        check("R1 byte2", byte_at(2), 8'h00); check("R1 byte3", byte_at(3), 8'h01);
        check("R1 byte4", byte_at(4), 8'h01); check("R1 byte5", byte_at(5), 8'h01);
        check("R1 byte6", byte_at(6), 8'h00); check("R1 byte7", byte_at(7), 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1;

        // R13: distinct values land on their own byte lanes
        wr_reg(3'd7, 8'h5A);
        set_all(8'h42, 8'h17, 8'h09, 8'h04, 8'h15, 8'h08, 8'h37);
        check("R13 sec lane",  byte_at(0), 8'h42); check("R13 min lane",  byte_at(1), 8'h17);
        check("R13 hrs lane",  byte_at(2), 8'h09); check("R13 dow lane",  byte_at(3), 8'h04);
        check("R13 date lane", byte_at(4), 8'h15); check("R13 mon lane",  byte_at(5), 8'h08);
        check("R13 year lane", byte_at(6), 8'h37); check("R13 cal lane",  byte_at(7), 8'h5A);

        // R10: masking of unused bits
        tick_en = 1'b0;
        wr_reg(3'd5, 8'hE9);
        check("R10 month mask", byte_at(5), 8'h09);
        wr_reg(3'd3, 8'hF2);
        check("R10 weekday mask", byte_at(3), 8'h02);

        // R10: seconds write restarts the prescaler
        set_all(8'h30, 8'h10, 8'h12, 8'h02, 8'h10, 8'h06, 8'h21);
        check("R10 restart e0", byte_at(0), 8'h30);
        repeat (3) @(negedge clk);
        check("R10 restart e3", byte_at(0), 8'h30);
        @(negedge clk);
        check("R10 restart e4", byte_at(0), 8'h31);

        // R2: BCD digit carry 09 -> 10
        set_all(8'h09, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01);
        repeat (4) @(negedge clk);
        check("R2 bcd carry", byte_at(0), 8'h10);

        // R4 R5 R8 R9: full wrap with century enabled
        set_all(8'h59, 8'h59, 8'h63, 8'h07, 8'h31, 8'h12, 8'h99);
        repeat (4) @(negedge clk);
        check("R9 century set", byte_at(2), 8'hC0);
        check("R5 weekday wrap", byte_at(3), 8'h01);
        check("R8 month wrap", byte_at(5), 8'h01);
        check("R8 year wrap", byte_at(6), 8'h00);

        // R9: already set with enable -> clears; no enable -> untouched
        set_all(8'h59, 8'h59, 8'hE3, 8'h03, 8'h31, 8'h12, 8'h99);
        repeat (4) @(negedge clk);
        check("R9 century clear", byte_at(2), 8'h40);
        set_all(8'h59, 8'h59, 8'h23, 8'h03, 8'h31, 8'h12, 8'h99);
        repeat (4) @(negedge clk);
        check("R9 century disabled", byte_at(2), 8'h00);

        // R6: non-leap February and 30-day month
        set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
        repeat (4) @(negedge clk);
        check("R6 feb28 date", byte_at(4), 8'h01); check("R6 feb28 month", byte_at(5), 8'h03);
        set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h23);
        repeat (4) @(negedge clk);
        check("R6 apr30 date", byte_at(4), 8'h01); check("R6 apr30 month", byte_at(5), 8'h05);

        // R7: leap February
        set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h28, 8'h02, 8'h24);
        repeat (4) @(negedge clk);
        check("R7 leap day", byte_at(4), 8'h29); check("R7 leap month", byte_at(5), 8'h02);
        set_all(8'h59, 8'h59, 8'h23, 8'h06, 8'h29, 8'h02, 8'h24);
        repeat (4) @(negedge clk);
        check("R7 after leap day", byte_at(4), 8'h01); check("R7 after leap month", byte_at(5), 8'h03);

        // R11: minutes write on the exact boundary edge
        set_all(8'h59, 8'h59, 8'h05, 8'h01, 8'h10, 8'h03, 8'h22);
        repeat (3) @(negedge clk);
        wr_reg(3'd1, 8'h10);
        check("R11 write wins min", byte_at(1), 8'h10);
        check("R11 sec advanced", byte_at(0), 8'h00);
        check("R11 hour carried", byte_at(2), 8'h06);

        // R12: calibration stored, rate unchanged
        wr_reg(3'd7, 8'hA5);
        check("R12 calib stored", byte_at(7), 8'hA5);
        set_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        repeat (4) @(negedge clk);
        check("R12 rate kept", byte_at(0), 8'h01);

        // Long random-gap runs with sparse random writes
        set_all(8'h50, 8'h34, 8'h12, 8'h03, 8'h20, 8'h07, 8'h45);
        gap_en = 1'b1;
        repeat (3000) @(negedge clk);
        set_all(8'h00, 8'h58, 8'hE3, 8'h07, 8'h28, 8'h02, 8'h99);
        for (int i = 0; i < 80; i++) begin
            repeat (37) @(negedge clk);
            case ($urandom % 3)
                0: wr_reg(3'd0, to_bcd(int'($urandom % 60)));
                1: wr_reg(3'd1, to_bcd(int'($urandom % 60)));
                default: wr_reg(3'd7, 8'($urandom));
            endcase
        end
        gap_en = 1'b0;
        repeat (20) @(negedge clk);

        done = 1;
        summary();
        $finish;
    end
endmodule